// File: doc/BRIEF.md
# Correlating Two-Level Branch Direction Predictor

This block guesses whether a conditional branch will be taken, using two kinds of past behaviour at once. The behaviour of the branch itself is held in a small table of saturating counters. The outcomes of the most recent branches of any kind are held in a short global history register. The table is indexed by a few low bits of the branch address. Each address slot holds one counter for every possible history pattern, and the current history picks which of those counters speaks.

The fetch stage presents a program counter and gets a direction in the same cycle. It also gets the history value that was used, and carries it down the pipeline with the branch. When the branch resolves, the back end returns the branch address, the real outcome and that carried history value. Only the counter that made the guess is trained, and the outcome is shifted into the global history. Target addresses, tag checks and repair of the history after a wrong path are left to neighbouring blocks.

Top module: `corr_bpred`

## Requirements
- R1: After reset every counter holds 1 (weakly not taken) and the global history is 00, so every lookup predicts not taken and `lk_hist` reads 00.
- R2: The slot is chosen by PC bits [5:2] (four bits above the word offset) with no tag compare, so PCs that differ only above bit 5 share the same counters.
- R3: An update trains only the counter at slot `up_pc[5:2]` and history `up_hist`. The other three counters of that slot and all other slots keep their values.
- R4: A counter steps up by one on a taken outcome and down by one on a not-taken outcome. It saturates at 0 and at 3 and never wraps.
- R5: A lookup predicts taken exactly when the selected counter is 2 or 3. From a saturated state the prediction flips only after two consecutive opposite outcomes.
- R6: A lookup reads the counter of its slot selected by the current global history, and presents that history on `lk_hist` in the same cycle.
- R7: On each update the history shifts left by one and `up_taken` enters bit 0. A history of 01 therefore means the older branch was not taken and the newest was taken.
- R8: While `up_valid` is low, `up_pc`, `up_taken` and `up_hist` have no effect: no counter and no history bit changes.
- R9: When a lookup and an update address the same counter in one cycle, the lookup returns the prediction from the value before the update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | PC_W | Fetch address to predict |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| lk_hist | output | HIST_W | Global history used by this lookup |
| up_valid | input | 1 | A resolved branch is presented this cycle |
| up_pc | input | PC_W | Address of the resolved branch |
| up_taken | input | 1 | Real outcome of the resolved branch |
| up_hist | input | HIST_W | History value carried from that branch's lookup |

## Verification
Assertions watch every counter on every cycle. They check single steps, saturation at both ends, and that counters and history stay unchanged when nothing writes them. They also check the shift of the history and that at most one counter is written in a cycle. Which counter a lookup reads, the aliasing of addresses that differ only in their high bits, and the isolation of a slot's four counters from one another can only be seen through the bench's scenarios. The same holds for the two-miss hysteresis and the pre-update value on a same-cycle collision. The bench compares against a model that follows the requirements.

// File: rtl/corr_bpred_pkg.sv
package corr_bpred_pkg;

   localparam int unsigned DEF_PC_W     = 32;
   localparam int unsigned DEF_PC_SHIFT = 2;
   localparam int unsigned DEF_IDX_W    = 4;
   localparam int unsigned DEF_HIST_W   = 2;
   localparam int unsigned DEF_CTR_W    = 2;

   // Saturating step of a counter of up to 16 bits, clamped to [0, maxv].
   function automatic logic [15:0] sat_step(input logic [15:0] v,
                                            input logic        up,
                                            input logic [15:0] maxv);
      logic [15:0] r;
      r = v;
      if (up) begin
         if (v != maxv) r = v + 16'd1;
      end else begin
         if (v != 16'd0) r = v - 16'd1;
      end
      return r;
   endfunction

endpackage

// File: rtl/bp_sat_ctr.sv
module bp_sat_ctr #(
   parameter int unsigned CTR_W    = 2,
   parameter int unsigned CTR_INIT = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             inc,
   output logic [CTR_W-1:0] val
);
   localparam logic [CTR_W-1:0] MAXV = CTR_W'((1 << CTR_W) - 1);

   logic [CTR_W-1:0] q;

   always_ff @(posedge clk) begin
      if (!rst_n)  q <= CTR_W'(CTR_INIT);
      else if (en) q <= CTR_W'(corr_bpred_pkg::sat_step(16'(q), inc, 16'(MAXV)));
   end

   assign val = q;

   // R4: a non-saturated counter moves by exactly one step
   a_r4_step_up: assert property (@(posedge clk) disable iff (!rst_n)
      (en && inc && q != MAXV) |=> (q == CTR_W'($past(q) + 1'b1)));
   a_r4_step_dn: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !inc && q != '0) |=> (q == CTR_W'($past(q) - 1'b1)));
   // R4: no wrap at either end
   a_r4_sat_top: assert property (@(posedge clk) disable iff (!rst_n)
      (en && inc && q == MAXV) |=> (q == MAXV));
   a_r4_sat_bot: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !inc && q == '0) |=> (q == '0));
   // R3 / R8: an unselected counter keeps its value
   a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(q));
endmodule

// File: rtl/bp_ghr.sv
module bp_ghr #(
   parameter int unsigned HIST_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic              bit_in,
   output logic [HIST_W-1:0] hist
);
   logic [HIST_W-1:0] q;

   always_ff @(posedge clk) begin
      if (!rst_n)        q <= '0;
      else if (shift_en) q <= {q[HIST_W-2:0], bit_in};
   end

   assign hist = q;

   // R7: newest outcome enters bit 0, older bits move up
   a_r7_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en |=> (hist[0] == $past(bit_in)) && (hist[HIST_W-1:1] == $past(hist[HIST_W-2:0])));
   // R8: no update, no history change
   a_r8_hist_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_en |=> $stable(hist));
endmodule

// File: rtl/bp_table.sv
module bp_table #(
   parameter int unsigned SEL_W    = 6,
   parameter int unsigned CTR_W    = 2,
   parameter int unsigned CTR_INIT = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [SEL_W-1:0] wr_sel,
   input  logic             wr_inc,
   input  logic [SEL_W-1:0] rd_sel,
   output logic [CTR_W-1:0] rd_ctr
);
   localparam int unsigned N_ENT = 1 << SEL_W;

   logic [CTR_W-1:0] ctr_q [N_ENT];
   logic [N_ENT-1:0] ent_we;

   for (genvar i = 0; i < N_ENT; i++) begin : g_ent
      assign ent_we[i] = wr_en && (wr_sel == SEL_W'(i));
      bp_sat_ctr #(.CTR_W(CTR_W), .CTR_INIT(CTR_INIT)) u_ctr (
         .clk  (clk),
         .rst_n(rst_n),
         .en   (ent_we[i]),
         .inc  (wr_inc),
         .val  (ctr_q[i])
      );
   end

   // Read port sees register outputs, i.e. the value before any write this cycle (R9)
   assign rd_ctr = ctr_q[rd_sel];

   // R3: at most one counter is trained per cycle
   a_r3_single_write: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ent_we));
   // R8: no write strobe without a valid update
   a_r8_no_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |-> (ent_we == '0));
endmodule

// File: rtl/corr_bpred.sv
module corr_bpred #(
   parameter int unsigned PC_W     = corr_bpred_pkg::DEF_PC_W,
   parameter int unsigned PC_SHIFT = corr_bpred_pkg::DEF_PC_SHIFT,
   parameter int unsigned IDX_W    = corr_bpred_pkg::DEF_IDX_W,
   parameter int unsigned HIST_W   = corr_bpred_pkg::DEF_HIST_W,
   parameter int unsigned CTR_W    = corr_bpred_pkg::DEF_CTR_W,
   parameter int unsigned CTR_INIT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PC_W-1:0]   lk_pc,
   output logic              lk_taken,
   output logic [HIST_W-1:0] lk_hist,
   input  logic              up_valid,
   input  logic [PC_W-1:0]   up_pc,
   input  logic              up_taken,
   input  logic [HIST_W-1:0] up_hist
);
   localparam int unsigned SEL_W = IDX_W + HIST_W;

   if (PC_SHIFT + IDX_W > PC_W) begin : g_bad_pc
      $error("corr_bpred: index field lies outside the PC");
   end
   if (HIST_W < 2 || HIST_W > 12) begin : g_bad_hist
      $error("corr_bpred: HIST_W must be 2..12");
   end
   if (CTR_W < 2 || CTR_W > 8) begin : g_bad_ctr
      $error("corr_bpred: CTR_W must be 2..8");
   end
   if (CTR_INIT >= (1 << CTR_W)) begin : g_bad_init
      $error("corr_bpred: CTR_INIT exceeds counter range");
   end
   if (SEL_W > 10) begin : g_bad_size
      $error("corr_bpred: table too large");
   end

   logic [HIST_W-1:0] ghist;
   logic [SEL_W-1:0]  lk_sel;
   logic [SEL_W-1:0]  up_sel;
   logic [CTR_W-1:0]  lk_ctr;
   logic              unused_pc_bits;

   assign unused_pc_bits = ^{lk_pc, up_pc};

   // Slot bits above the history bits: one group of 2**HIST_W counters per slot
   assign lk_sel = {lk_pc[PC_SHIFT +: IDX_W], ghist};
   assign up_sel = {up_pc[PC_SHIFT +: IDX_W], up_hist};

   bp_ghr #(.HIST_W(HIST_W)) u_ghr (
      .clk     (clk),
      .rst_n   (rst_n),
      .shift_en(up_valid),
      .bit_in  (up_taken),
      .hist    (ghist)
   );

   bp_table #(.SEL_W(SEL_W), .CTR_W(CTR_W), .CTR_INIT(CTR_INIT)) u_tbl (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (up_valid),
      .wr_sel(up_sel),
      .wr_inc(up_taken),
      .rd_sel(lk_sel),
      .rd_ctr(lk_ctr)
   );

   assign lk_taken = lk_ctr[CTR_W-1];
   assign lk_hist  = ghist;

   // R1: the first cycle after reset shows an empty history
   a_r1_hist_clear: assert property (@(posedge clk)
      !rst_n |=> (lk_hist == '0));
endmodule

// File: tb/corr_bpred_bench.sv
module corr_bpred_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] lk_pc = '0;
   logic        lk_taken;
   logic [1:0]  lk_hist;
   logic        up_valid = 1'b0;
   logic [31:0] up_pc = '0;
   logic        up_taken = 1'b0;
   logic [1:0]  up_hist = '0;

   int n_chk = 0;
   int n_fail = 0;
   int m_ctr [16][4];
   int m_hist;

   always #5 clk = ~clk;

   corr_bpred u_corr_bpred (
      .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken), .lk_hist(lk_hist),
      .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken), .up_hist(up_hist)
   );

   // {up_valid, up_pc, up_taken, up_hist, lk_pc}
   localparam logic [67:0] VEC [16] = '{
      {1'b1, 32'h0000_0004, 1'b1, 2'b00, 32'h0000_0004},
      {1'b1, 32'h0000_0004, 1'b1, 2'b01, 32'h0000_0004},
      {1'b1, 32'h0000_0008, 1'b0, 2'b11, 32'h0000_0004},
      {1'b1, 32'h0000_0004, 1'b1, 2'b10, 32'h0000_0004},
      {1'b0, 32'h0000_0004, 1'b1, 2'b00, 32'h0000_0004},
      {1'b1, 32'h0000_0010, 1'b1, 2'b00, 32'h0000_0010},
      {1'b1, 32'h0000_0010, 1'b1, 2'b01, 32'h0000_0010},
      {1'b1, 32'h0000_0010, 1'b1, 2'b11, 32'h0000_0010},
      {1'b1, 32'h0000_0010, 1'b1, 2'b11, 32'hF000_0010},
      {1'b1, 32'h0000_0010, 1'b0, 2'b11, 32'h0000_0010},
      {1'b1, 32'h0000_003C, 1'b1, 2'b10, 32'h0000_0038},
      {1'b1, 32'h0000_0038, 1'b0, 2'b01, 32'h0000_0038},
      {1'b0, 32'h0000_0038, 1'b0, 2'b00, 32'h0000_0010},
      {1'b1, 32'h0000_0020, 1'b1, 2'b10, 32'h0000_0020},
      {1'b1, 32'h0000_0020, 1'b1, 2'b01, 32'h0000_0020},
      {1'b1, 32'h0000_0020, 1'b1, 2'b11, 32'h1234_5660}
   };

   task automatic chk(input int act, input int exp, input string req, input string what);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int s = 0; s < 16; s++)
         for (int h = 0; h < 4; h++) m_ctr[s][h] = 1;
      m_hist = 0;
   endtask

   // One cycle: drive at negedge, check the combinational lookup, then let the edge update state.
   task automatic step(input logic uv, input logic [31:0] upc, input logic ut,
                       input logic [1:0] uh, input logic [31:0] lpc, input string req);
      int s;
      int exp_t;
      @(negedge clk);
      up_valid = uv; up_pc = upc; up_taken = ut; up_hist = uh; lk_pc = lpc;
      #2;
      exp_t = (m_ctr[int'(lpc[5:2])][m_hist] >= 2) ? 1 : 0;
      chk(int'(lk_taken), exp_t, req, "lk_taken");
      chk(int'(lk_hist), m_hist, req, "lk_hist");
      @(posedge clk);
      if (uv) begin
         s = int'(upc[5:2]);
         if (ut && m_ctr[s][uh] < 3) m_ctr[s][uh]++;
         if (!ut && m_ctr[s][uh] > 0) m_ctr[s][uh]--;
         m_hist = ((m_hist << 1) | int'(ut)) & 3;
      end
   endtask

   task automatic set_hist(input logic [1:0] h);
      step(1'b1, 32'h0000_003C, h[1], 2'b11, 32'h0000_003C, "R7");
      step(1'b1, 32'h0000_003C, h[0], 2'b11, 32'h0000_003C, "R7");
   endtask

   task automatic peek(input logic [31:0] pc, input string req);
      step(1'b0, 32'h0, 1'b0, 2'b00, pc, req);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; up_valid = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      model_reset();
   endtask

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      do_reset();
      // R1: every slot predicts not taken with an empty history
      for (int s = 0; s < 16; s++) peek(32'(s * 4), "R1");

      // Table walk: R3 R6 R7 R2 R9 mixtures
      for (int i = 0; i < 16; i++)
         step(VEC[i][67], VEC[i][66:35], VEC[i][34], VEC[i][33:32], VEC[i][31:0], "R6");

      // R4 / R5: saturate upward, then two misses needed to flip
      do_reset();
      repeat (5) step(1'b1, 32'h1C, 1'b1, 2'b00, 32'h0, "R4");
      set_hist(2'b00); peek(32'h1C, "R4");
      step(1'b1, 32'h1C, 1'b0, 2'b00, 32'h0, "R5");
      set_hist(2'b00); peek(32'h1C, "R5");
      step(1'b1, 32'h1C, 1'b0, 2'b00, 32'h0, "R5");
      set_hist(2'b00); peek(32'h1C, "R5");
      // R4: saturate at the bottom, climb back
      repeat (4) step(1'b1, 32'h1C, 1'b0, 2'b00, 32'h0, "R4");
      step(1'b1, 32'h1C, 1'b1, 2'b00, 32'h0, "R4");
      set_hist(2'b00); peek(32'h1C, "R4");
      step(1'b1, 32'h1C, 1'b1, 2'b00, 32'h0, "R4");
      set_hist(2'b00); peek(32'h1C, "R4");

      // R8: inputs with up_valid low change nothing
      repeat (4) step(1'b0, 32'h1C, 1'b1, 2'b00, 32'h1C, "R8");
      repeat (3) step(1'b0, 32'h1C, 1'b0, 2'b00, 32'h1C, "R8");

      // R3: train history 01 of slot 2 only; history 00 of the same slot stays
      step(1'b1, 32'h08, 1'b1, 2'b01, 32'h0, "R3");
      step(1'b1, 32'h08, 1'b1, 2'b01, 32'h0, "R3");
      set_hist(2'b00); peek(32'h08, "R3");
      set_hist(2'b01); peek(32'h08, "R3");
      // R2: high PC bits ignored in indexing
      peek(32'hFFFF_FF08, "R2");
      set_hist(2'b10); peek(32'hABCD_EF08, "R2");

      // R7: each history pattern visible on lk_hist
      set_hist(2'b01); peek(32'h0, "R7");
      set_hist(2'b10); peek(32'h0, "R7");
      set_hist(2'b11); peek(32'h0, "R7");

      // R9: collision returns the pre-update value
      set_hist(2'b10);
      step(1'b1, 32'h24, 1'b1, 2'b10, 32'h24, "R9");
      set_hist(2'b10);
      step(1'b1, 32'h24, 1'b1, 2'b10, 32'h24, "R9");
      set_hist(2'b10); peek(32'h24, "R9");

      // R1: a second reset clears trained state
      do_reset();
      peek(32'h1C, "R1"); peek(32'h08, "R1");

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule